// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service on a schedule. A 24-bit down-counter advances once for every four watchdog clocks. When it runs out, the block either records the event and restarts, or asks for a system reset. Software configures the block and services it through a plain write port (strobe, address, data). Servicing the counter is called a feed: two writes to the feed register, 0xAA and then 0x55.

Three optional protections make a stuck or runaway program more likely to be caught. A window limit rejects feeds that arrive too early. A bad feed sequence raises a reset at once when reset mode is on. A protect mode freezes the reload value until the count has dropped to the warning level. A sticky warning interrupt fires at a chosen count ahead of the timeout.

The enable, the reset mode and the protect mode can be set but never cleared by software. Only the hardware reset input or a watchdog-generated reset clears them. In this block the register port and the counter share one clock. Crossing between clock domains is left to the surrounding logic.

Top module: `wwd_timer`

## Requirements
- R1: After hardware reset the reload value and the count are MIN_TC, the window limit is all ones, the warning value is 0, and the enable, reset output, warning interrupt and timeout flag are all 0.
- R2: A valid feed is a write of 0xAA to the feed register (address 2) followed directly by a write of 0x55 to the same register. It loads the count from the reload value and restarts the divide-by-4 prescaler. The count then falls by one every 4 clocks, but only if the enable was set when the feed happened. Before such a feed the count holds still.
- R3: A reload value below MIN_TC, written to address 1, is stored as MIN_TC.
- R4: With enable on and reset mode off, the clock edge that would take the count below zero sets the timeout flag and reloads the count, so a feed with reload value T times out 4·(T+1) clocks after the feed write.
- R5: With enable and reset mode both on, a timeout raises the reset output for exactly 4 clocks. The same edge sets the timeout flag, clears the enable, the reset mode and the protect mode, and restores the reload value, warning value, window limit and count to their reset values. Writes are ignored while the reset output is high.
- R6: The warning interrupt is set on the count step that makes the count equal to the warning value (address 3). It stays set until software writes 1 to control bit 3 (address 0).
- R7: Control bit 0 (enable), bit 1 (reset mode) and bit 4 (protect) are set by writing 1 to them. Writing 0 has no effect on them.
- R8: A complete feed made while the count is above the window limit (address 4) does not reload the count. With reset mode off it has no other effect.
- R9: With enable and reset mode on, any write that directly follows a 0xAA feed write and is not 0x55 to the feed register triggers the watchdog reset of R5 on that edge.
- R10: With protect set, a write to the reload value takes effect only while the count is at or below the warning value. Otherwise the write is dropped.
- R11: The timeout flag survives a watchdog reset. It is cleared by the hardware reset or by writing 1 to control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and register clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 reload, 2 feed, 3 warning, 4 window |
| wr_data | input | CNT_W | Write data |
| wd_rst_o | output | 1 | System reset request |
| warn_irq_o | output | 1 | Sticky warning interrupt |
| tof_o | output | 1 | Timeout flag |
| en_o | output | 1 | Enable state |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with CNT_W = 12, WARN_W = 6, PRESC = 4 and MIN_TC = 15. With these values the shortest timeout is 64 clocks, so complete countdowns can be run many times in a short run. These include the exact timeout edge in both modes, the warning crossing, and the protect and window limits around it. The 12-bit counter still allows a 4095 reload, which tests the top of the range. The 6-bit warning field holds the warning value used in the protect and window tests.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_FEED   = 3'd2,
        A_WARN   = 3'd3,
        A_WIN    = 3'd4
    } reg_addr_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_KEY1 = 1'b1
    } feed_st_e;

    localparam logic [7:0] FEED_KEY1 = 8'hAA;
    localparam logic [7:0] FEED_KEY2 = 8'h55;

    localparam int CB_EN   = 0;
    localparam int CB_RSTM = 1;
    localparam int CB_TOF  = 2;
    localparam int CB_WINT = 3;
    localparam int CB_PROT = 4;

    typedef struct packed {
        logic prot;
        logic rst_mode;
        logic en;
    } mode_t;

    localparam mode_t MODE_OFF = '{prot: 1'b0, rst_mode: 1'b0, en: 1'b0};

endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale #(
    parameter int PRESC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2: count steps are spaced by the prescaler, never back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wwd_feed_seq.sv
module wwd_feed_seq
    import wwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr_ok,
    input  logic       is_feed,
    input  logic [7:0] wbyte,
    output logic       feed_ok,
    output logic       seq_err
);
    feed_st_e st_q;
    logic     key2_hit;

    assign key2_hit = is_feed && (wbyte == FEED_KEY2);

    always_comb begin
        feed_ok = wr_ok && (st_q == FS_KEY1) && key2_hit;
        seq_err = wr_ok && (st_q == FS_KEY1) && !key2_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= FS_IDLE;
        end else if (wr_ok) begin
            if (st_q == FS_IDLE && is_feed && wbyte == FEED_KEY1) begin
                st_q <= FS_KEY1;
            end else begin
                st_q <= FS_IDLE;
            end
        end
    end

    // R9: after any write that follows a first key, the sequence starts over
    a_r9_seq_restarts: assert property (@(posedge clk) disable iff (rst)
        (st_q == FS_KEY1 && wr_ok) |=> (st_q == FS_IDLE));

endmodule

// File: rtl/wwd_timer.sv
module wwd_timer
    import wwd_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WARN_W = 10,
    parameter int PRESC  = 4,
    parameter int MIN_TC = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             wd_rst_o,
    output logic             warn_irq_o,
    output logic             tof_o,
    output logic             en_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0]    HOLD_LAST = PW'(PRESC - 1);
    localparam logic [CNT_W-1:0] TC_MIN    = CNT_W'(MIN_TC);

    reg_addr_e         addr;
    mode_t             mode_q;
    logic [CNT_W-1:0]  cnt_q, tc_q, win_q;
    logic [WARN_W-1:0] warn_q;
    logic [PW-1:0]     hold_q;
    logic              armed_q, tof_q, wint_q, rst_q;

    logic              wr_ok, ctrl_wr, tc_wr, tick;
    logic              feed_ok, seq_err, feed_load, feed_bad;
    logic              timeout, wd_evt, warn_hit;
    logic [CNT_W-1:0]  warn_ext, cnt_dec, tc_clamped;

    assign addr       = reg_addr_e'(wr_addr);
    assign wr_ok      = wr_en && !rst_q;
    assign ctrl_wr    = wr_ok && (addr == A_CTRL);
    assign warn_ext   = CNT_W'(warn_q);
    assign cnt_dec    = cnt_q - 1'b1;
    assign tc_clamped = (wr_data < TC_MIN) ? TC_MIN : wr_data;
    assign tc_wr      = wr_ok && (addr == A_RELOAD) && (!mode_q.prot || (cnt_q <= warn_ext));
    assign feed_load  = feed_ok && (cnt_q <= win_q);
    assign feed_bad   = feed_ok && (cnt_q > win_q);
    assign timeout    = armed_q && tick && (cnt_q == '0);
    assign warn_hit   = armed_q && tick && (cnt_q != '0) && (cnt_dec == warn_ext);
    assign wd_evt     = mode_q.en && mode_q.rst_mode && (timeout || seq_err || feed_bad);

    wwd_prescale #(.PRESC(PRESC)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (feed_load || wd_evt),
        .run  (armed_q),
        .tick (tick)
    );

    wwd_feed_seq u_feed (
        .clk     (clk),
        .rst     (rst),
        .clr     (wd_evt),
        .wr_ok   (wr_ok),
        .is_feed (addr == A_FEED),
        .wbyte   (wr_data[7:0]),
        .feed_ok (feed_ok),
        .seq_err (seq_err)
    );

    always_ff @(posedge clk) begin
        if (rst || wd_evt) begin
            mode_q  <= MODE_OFF;
            cnt_q   <= TC_MIN;
            tc_q    <= TC_MIN;
            win_q   <= '1;
            warn_q  <= '0;
            armed_q <= 1'b0;
            wint_q  <= 1'b0;
            tof_q   <= !rst;
            rst_q   <= !rst;
            hold_q  <= HOLD_LAST;
        end else begin
            if (rst_q) begin
                if (hold_q == '0) rst_q <= 1'b0;
                else              hold_q <= hold_q - 1'b1;
            end
            if (ctrl_wr) begin
                mode_q.en       <= mode_q.en       | wr_data[CB_EN];
                mode_q.rst_mode <= mode_q.rst_mode | wr_data[CB_RSTM];
                mode_q.prot     <= mode_q.prot     | wr_data[CB_PROT];
                if (wr_data[CB_TOF])  tof_q  <= 1'b0;
                if (wr_data[CB_WINT]) wint_q <= 1'b0;
            end
            if (tc_wr)                          tc_q   <= tc_clamped;
            if (wr_ok && addr == A_WARN)        warn_q <= wr_data[WARN_W-1:0];
            if (wr_ok && addr == A_WIN)         win_q  <= wr_data;
            if (feed_load) begin
                cnt_q   <= tc_q;
                armed_q <= mode_q.en;
            end else if (armed_q && tick) begin
                if (cnt_q == '0) begin
                    cnt_q <= tc_q;
                    tof_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_dec;
                end
            end
            if (warn_hit) wint_q <= 1'b1;
        end
    end

    assign wd_rst_o   = rst_q;
    assign warn_irq_o = wint_q;
    assign tof_o      = tof_q;
    assign en_o       = mode_q.en;
    assign count_o    = cnt_q;

    // R5: while the reset request is out, the enable has been wiped
    a_r5_rst_clears_en: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !mode_q.en);

    // R7: only a watchdog or hardware reset drops the enable
    a_r7_en_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_q.en && !wd_evt) |=> mode_q.en);

    // R6: the warning flag holds until cleared by a write of 1
    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (wint_q && !wd_evt && !(ctrl_wr && wr_data[CB_WINT])) |=> wint_q);

    // R2: an idle counter moves only through a feed or a watchdog reset
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !feed_load && !wd_evt) |=> $stable(cnt_q));

    // R10: a protected reload value ignores writes above the warning level
    a_r10_protect: assert property (@(posedge clk) disable iff (rst)
        (mode_q.prot && wr_ok && addr == A_RELOAD && cnt_q > warn_ext && !wd_evt)
        |=> $stable(tc_q));

endmodule

// File: tb/tb_wwd_timer.sv
module tb_wwd_timer;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          wd_rst_o, warn_irq_o, tof_o, en_o;
    logic [CW-1:0] count_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wwd_timer #(.CNT_W(CW), .WARN_W(6), .PRESC(4), .MIN_TC(15)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wd_rst_o(wd_rst_o), .warn_irq_o(warn_irq_o), .tof_o(tof_o),
        .en_o(en_o), .count_o(count_o)
    );

    typedef struct packed {
        logic [15:0] tc;
        logic [15:0] wt;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{tc: 16'd5,    wt: 16'd20,  exp: 16'd10},
        '{tc: 16'd100,  wt: 16'd40,  exp: 16'd90},
        '{tc: 16'd4095, wt: 16'd400, exp: 16'd3995},
        '{tc: 16'd200,  wt: 16'd3,   exp: 16'd200},
        '{tc: 16'd64,   wt: 16'd17,  exp: 16'd60},
        '{tc: 16'd15,   wt: 16'd60,  exp: 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic feed();
        wr(3'd2, 12'h0AA);
        wr(3'd2, 12'h055);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", 32'(count_o), 15);
        chk("R1 en", 32'(en_o), 0);
        chk("R1 rst_o", 32'(wd_rst_o), 0);
        chk("R1 irq", 32'(warn_irq_o), 0);
        chk("R1 tof", 32'(tof_o), 0);

        // R2 enabled but not fed: count holds
        wr(3'd0, 12'h001);
        idle(20);
        chk("R2 no run before feed", 32'(count_o), 15);
        // R7 writing 0 leaves enable set
        wr(3'd0, 12'h000);
        chk("R7 enable sticky", 32'(en_o), 1);

        // R2/R3 vector table: reload, feed, wait, expected count
        foreach (VECS[i]) begin
            wr(3'd1, VECS[i].tc[CW-1:0]);
            feed();
            idle(int'(VECS[i].wt));
            chk($sformatf("R2/R3 vector %0d", i), 32'(count_o), 32'(VECS[i].exp));
        end

        // R4 timeout without reset mode (reload 15 -> 64 clocks)
        feed();
        wr(3'd0, 12'h005);
        idle(62);
        chk("R4 tof before timeout", 32'(tof_o), 0);
        chk("R4 count at zero", 32'(count_o), 0);
        idle(1);
        chk("R4 tof at timeout", 32'(tof_o), 1);
        chk("R4 reloaded", 32'(count_o), 15);
        chk("R4 no reset", 32'(wd_rst_o), 0);

        // R6 warning interrupt at count 10
        wr(3'd3, 12'd10);
        feed();
        wr(3'd0, 12'h009);
        idle(18);
        chk("R6 irq low at 11", 32'(warn_irq_o), 0);
        chk("R6 count 11", 32'(count_o), 11);
        idle(1);
        chk("R6 irq set at 10", 32'(warn_irq_o), 1);
        idle(8);
        chk("R6 irq sticky", 32'(warn_irq_o), 1);
        wr(3'd0, 12'h009);
        chk("R6 irq cleared", 32'(warn_irq_o), 0);

        // R10 protect mode
        wr(3'd1, 12'd100);
        feed();
        chk("R10 reload 100", 32'(count_o), 100);
        wr(3'd0, 12'h011);
        wr(3'd1, 12'd50);
        feed();
        chk("R10 write above warning dropped", 32'(count_o), 100);
        idle(368);
        chk("R10 count 8", 32'(count_o), 8);
        wr(3'd1, 12'd50);
        feed();
        chk("R10 write below warning taken", 32'(count_o), 50);

        // R8 window limit
        wr(3'd4, 12'd20);
        idle(7);
        feed();
        chk("R8 early feed ignored", 32'(count_o), 48);
        chk("R8 no reset", 32'(wd_rst_o), 0);
        idle(120);
        chk("R8 count 18", 32'(count_o), 18);
        feed();
        chk("R8 feed in window reloads", 32'(count_o), 50);

        // R9 bad sequence in reset mode; R11 software clear
        wr(3'd0, 12'h007);
        chk("R11 tof cleared by write", 32'(tof_o), 0);
        wr(3'd2, 12'h0AA);
        wr(3'd2, 12'h012);
        chk("R9 reset raised", 32'(wd_rst_o), 1);
        chk("R5 enable cleared", 32'(en_o), 0);
        chk("R5 tof set", 32'(tof_o), 1);
        chk("R5 count restored", 32'(count_o), 15);
        idle(3);
        chk("R5 reset still high", 32'(wd_rst_o), 1);
        idle(1);
        chk("R5 reset dropped after 4", 32'(wd_rst_o), 0);
        chk("R11 tof survives watchdog reset", 32'(tof_o), 1);

        // R5 timeout in reset mode
        wr(3'd0, 12'h007);
        chk("R11 tof cleared again", 32'(tof_o), 0);
        feed();
        idle(63);
        chk("R5 no reset before timeout", 32'(wd_rst_o), 0);
        idle(1);
        chk("R5 reset on timeout", 32'(wd_rst_o), 1);
        chk("R5 enable off", 32'(en_o), 0);
        chk("R5 tof on", 32'(tof_o), 1);
        idle(4);

        // R11 hardware reset clears tof; R2 feed while disabled does not run
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        chk("R11 tof cleared by hw reset", 32'(tof_o), 0);
        chk("R1 count after hw reset", 32'(count_o), 15);
        feed();
        idle(20);
        chk("R2 disabled feed does not run", 32'(count_o), 15);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule